// File: doc/BRIEF.md
# Line Buffer Configuration Selector

This block picks the line-buffer memory arrangement used by a vertical scaler. The line buffer can be split four ways, each giving a different amount of storage to luma, chroma and alpha. For a candidate arrangement the block works out how many whole source lines (partitions) fit in each plane's storage. It then asks whether those partitions are enough for the vertical filter, given the tap count and the rounded-up vertical scale ratio. It tries the arrangements in a fixed order and reports the first one that works. A software-style override skips the search and takes the largest arrangement for the format.

A search starts with a one-cycle `start` pulse. All other inputs must be held steady until `valid` rises. Every division, including the line-size roundings, goes through one shared restoring divider that produces one quotient bit per cycle. The chosen arrangement and its luma and chroma partition counts are registered and held until the next accepted start. A flag marks the case where even the final arrangement cannot hold the filter.

Top module: `lb_cfg_select`

## Requirements
- R1: The luma line length is the smaller of `vp_w_y` and `out_w`, and the chroma line length is the smaller of `vp_w_c` and `out_w`; a line length of 0 is treated as 1.
- R2: `bpc_code` selects the bits per component, with 0 meaning 10, 1 meaning 8, 2 meaning 6 and 3 meaning 12. The luma and chroma memory line sizes are ceil(length*bpc/72). The alpha line size is ceil(luma length/6).
- R3: The memory sizes per arrangement, as luma/chroma/alpha words, are: code 1 = 816/816/984; code 2 = 1088/1088/1312; code 3 = 3448/1904/2752; code 0 = 2752/2752/2752. The code is reported on `cfg`.
- R4: A plane's partition count is its memory size divided by its line size, rounded down. When `alpha_en` is 1, the luma count is lowered to the alpha count if that is smaller. Both reported counts are capped at 64. `parts_y` and `parts_c` give the counts of the reported arrangement.
- R5: An arrangement fits when, for luma and for chroma alike, taps <= partitions - ratio + 2 if the ceiling ratio is above 2, and otherwise taps <= partitions.
- R6: Without the override, the candidates are tried in the order 1, 2, then 3 (only when `is420` is 1), then 0. The first one that fits is reported.
- R7: With `use_max` set, the block reports code 3 if `is420` is 1 and code 0 otherwise, with no search. The partition counts and the error flag are still produced for that code.
- R8: `err` is 1 together with `valid` when the reported arrangement does not fit. Without the override, this happens only when the fallback code 0 also fails.
- R9: After reset, `valid`, `err`, `cfg`, `parts_y` and `parts_c` are all 0. `valid` is 0 in the cycle after a start is accepted. Once `valid` rises, it and all results hold steady until the next accepted start.
- R10: A `start` pulse that arrives while a search is running is ignored. This includes the cycle in which the final selection is made. Such a pulse changes neither the result nor the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a selection when idle |
| use_max | input | 1 | Override: take the largest arrangement for the format |
| is420 | input | 1 | Source is 4:2:0, which enables code 3 |
| alpha_en | input | 1 | Alpha plane is stored and limits luma |
| bpc_code | input | 2 | Bits per component selector |
| vp_w_y | input | WIDTH_W | Luma viewport width |
| vp_w_c | input | WIDTH_W | Chroma viewport width |
| out_w | input | WIDTH_W | Output rectangle width |
| vtaps_y | input | TAP_W | Luma vertical taps |
| vtaps_c | input | TAP_W | Chroma vertical taps |
| ceil_ry | input | RATIO_W | Ceiling of luma vertical ratio |
| ceil_rc | input | RATIO_W | Ceiling of chroma vertical ratio |
| cfg | output | 2 | Chosen arrangement code |
| parts_y | output | 7 | Luma partitions of the chosen arrangement |
| parts_c | output | 7 | Chroma partitions of the chosen arrangement |
| valid | output | 1 | Selection final |
| err | output | 1 | Chosen arrangement does not fit |

## Verification
Two things can happen in the same cycle: a new `start` request and the final evaluation step that raises `valid`. The bench first measures the start-to-valid latency of one search. It then repeats the same search and places a second `start` exactly on the edge where the selection completes. That second pulse must be dropped. The bench judges this by requiring `valid` to stay high with the same result for several cycles afterward, and by a separate run in which a pulse in the middle of the search leaves the latency unchanged.

// File: rtl/lb_cfg_select.sv
module lb_cfg_select #(
  parameter int WIDTH_W = 14,
  parameter int TAP_W   = 4,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               use_max,
  input  logic               is420,
  input  logic               alpha_en,
  input  logic [1:0]         bpc_code,
  input  logic [WIDTH_W-1:0] vp_w_y,
  input  logic [WIDTH_W-1:0] vp_w_c,
  input  logic [WIDTH_W-1:0] out_w,
  input  logic [TAP_W-1:0]   vtaps_y,
  input  logic [TAP_W-1:0]   vtaps_c,
  input  logic [RATIO_W-1:0] ceil_ry,
  input  logic [RATIO_W-1:0] ceil_rc,
  output logic [1:0]         cfg,
  output logic [6:0]         parts_y,
  output logic [6:0]         parts_c,
  output logic               valid,
  output logic               err
);
  // dividend holds length*12+71; WIDTH_W must be at least 8 so memory sizes fit
  localparam int DW = WIDTH_W + 5;
  localparam int CW = $clog2(DW);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DIV, S_EVAL} state_t;
  state_t st;

  logic [2:0]    op;
  logic [CW-1:0] cnt;
  logic [DW-1:0] quo, rem;
  logic [DW-1:0] res [0:5];

  logic [WIDTH_W-1:0] ly_min, lc_min, ly, lc;
  logic [3:0]         bpc;
  logic [DW-1:0]      dividend, divisor, trial, ylim;
  logic               ge, ok;
  logic [6:0]         py_cap, pc_cap;
  logic [1:0]         cfg_next;

  assign ly_min = (vp_w_y < out_w) ? vp_w_y : out_w;
  assign lc_min = (vp_w_c < out_w) ? vp_w_c : out_w;
  assign ly     = (ly_min == '0) ? WIDTH_W'(1) : ly_min;
  assign lc     = (lc_min == '0) ? WIDTH_W'(1) : lc_min;

  always_comb
    case (bpc_code)
      2'd0:    bpc = 4'd10;
      2'd1:    bpc = 4'd8;
      2'd2:    bpc = 4'd6;
      default: bpc = 4'd12;
    endcase

  function automatic logic [11:0] mem_words(input logic [1:0] c, input logic [1:0] plane);
    case (c)
      2'd1:    mem_words = (plane == 2'd2) ? 12'd984  : 12'd816;
      2'd2:    mem_words = (plane == 2'd2) ? 12'd1312 : 12'd1088;
      2'd3:    mem_words = (plane == 2'd0) ? 12'd3448 :
                           (plane == 2'd1) ? 12'd1904 : 12'd2752;
      default: mem_words = 12'd2752;
    endcase
  endfunction

  function automatic logic fits(input logic [TAP_W-1:0] vt, input logic [RATIO_W-1:0] r,
                                input logic [6:0] p);
    if (r > RATIO_W'(2)) fits = (16'(vt) + 16'(r) <= 16'(p) + 16'd2);
    else                 fits = (16'(vt) <= 16'(p));
  endfunction

  always_comb begin
    dividend = '0;
    divisor  = DW'(1);
    case (op)
      3'd0: begin dividend = DW'(ly) * DW'(bpc) + DW'(71); divisor = DW'(72); end
      3'd1: begin dividend = DW'(lc) * DW'(bpc) + DW'(71); divisor = DW'(72); end
      3'd2: begin dividend = DW'(ly) + DW'(5);             divisor = DW'(6);  end
      3'd3: begin dividend = DW'(mem_words(cfg, 2'd0));    divisor = res[0];  end
      3'd4: begin dividend = DW'(mem_words(cfg, 2'd1));    divisor = res[1];  end
      default: begin dividend = DW'(mem_words(cfg, 2'd2)); divisor = res[2];  end
    endcase
  end

  assign trial = {rem[DW-2:0], quo[DW-1]};
  assign ge    = trial >= divisor;

  assign ylim   = (alpha_en && res[5] < res[3]) ? res[5] : res[3];
  assign py_cap = (ylim   > DW'(64)) ? 7'd64 : ylim[6:0];
  assign pc_cap = (res[4] > DW'(64)) ? 7'd64 : res[4][6:0];
  assign ok     = fits(vtaps_y, ceil_ry, py_cap) && fits(vtaps_c, ceil_rc, pc_cap);

  always_comb
    case (cfg)
      2'd1:    cfg_next = 2'd2;
      2'd2:    cfg_next = is420 ? 2'd3 : 2'd0;
      default: cfg_next = 2'd0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;  op <= '0;  cnt <= '0;  quo <= '0;  rem <= '0;
      for (int i = 0; i < 6; i++) res[i] <= DW'(1);
      cfg <= '0;  parts_y <= '0;  parts_c <= '0;  valid <= 1'b0;  err <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            valid <= 1'b0;
            err   <= 1'b0;
            op    <= '0;
            cfg   <= use_max ? (is420 ? 2'd3 : 2'd0) : 2'd1;
            st    <= S_LOAD;
          end
        S_LOAD: begin
          quo <= dividend;
          rem <= '0;
          cnt <= '0;
          st  <= S_DIV;
        end
        S_DIV: begin
          quo <= {quo[DW-2:0], ge};
          rem <= ge ? trial - divisor : trial;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DW-1)) begin
            res[op] <= {quo[DW-2:0], ge};
            if (op == 3'd5) st <= S_EVAL;
            else begin
              op <= op + 3'd1;
              st <= S_LOAD;
            end
          end
        end
        default: begin
          parts_y <= py_cap;
          parts_c <= pc_cap;
          if (ok || use_max || cfg == 2'd0) begin
            valid <= 1'b1;
            err   <= !ok;
            st    <= S_IDLE;
          end else begin
            cfg <= cfg_next;
            op  <= 3'd3;
            st  <= S_LOAD;
          end
        end
      endcase
    end

  // restoring divider keeps its remainder below the divisor
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV) |-> (rem < divisor));
  a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (parts_y <= 7'd64 && parts_c <= 7'd64));
  a_r6_order_after_two: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVAL && !ok && !use_max && cfg == 2'd2) |=> (cfg == ($past(is420) ? 2'd3 : 2'd0)));
  a_r8_fallback_error: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVAL && !ok && cfg == 2'd0) |=> (valid && err));
  a_r8_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> valid);
  a_r9_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> !valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start) |=> (valid && $stable(cfg) && $stable(parts_y) && $stable(parts_c) && $stable(err)));
  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV && start) |=> (st == S_DIV || st == S_LOAD || st == S_EVAL));
endmodule

// File: tb/lb_cfg_select_test.sv
`timescale 1ns/1ps
module lb_cfg_select_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic use_max = 0, is420 = 0, alpha_en = 0;
  logic [1:0]  bpc_code = 0;
  logic [13:0] vp_w_y = 0, vp_w_c = 0, out_w = 0;
  logic [3:0]  vtaps_y = 0, vtaps_c = 0, ceil_ry = 0, ceil_rc = 0;
  logic [1:0]  cfg;
  logic [6:0]  parts_y, parts_c;
  logic        valid, err;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  lb_cfg_select uut (.clk, .rst_n, .start, .use_max, .is420, .alpha_en, .bpc_code,
    .vp_w_y, .vp_w_c, .out_w, .vtaps_y, .vtaps_c, .ceil_ry, .ceil_rc,
    .cfg, .parts_y, .parts_c, .valid, .err);

  typedef struct packed {
    logic [13:0] vy, vc, ow;
    logic [1:0]  bc;
    logic        al, f420, um;
    logic [3:0]  ty, tc, ry, rc;
    logic [1:0]  ecfg;
    logic        eerr;
  } vec_t;

  localparam vec_t TBL [0:14] = '{
    '{14'd1920, 14'd1920, 14'd1920, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd4, 4'd1, 4'd1, 2'd2, 1'b0}, // R6 cfg1 short
    '{14'd100,  14'd100,  14'd100,  2'd1, 1'b0, 1'b0, 1'b0, 4'd4, 4'd4, 4'd1, 4'd1, 2'd1, 1'b0}, // R4 cap
    '{14'd3840, 14'd3840, 14'd3840, 2'd3, 1'b0, 1'b0, 1'b0, 4'd4, 4'd4, 4'd1, 4'd1, 2'd0, 1'b0}, // R6 fallback
    '{14'd3840, 14'd3840, 14'd3840, 2'd3, 1'b0, 1'b0, 1'b0, 4'd6, 4'd6, 4'd1, 4'd1, 2'd0, 1'b1}, // R8
    '{14'd3840, 14'd1920, 14'd3840, 2'd0, 1'b0, 1'b1, 1'b0, 4'd4, 4'd4, 4'd1, 4'd1, 2'd3, 1'b0}, // R3 R6 420
    '{14'd1920, 14'd1920, 14'd1920, 2'd2, 1'b1, 1'b0, 1'b0, 4'd4, 4'd4, 4'd1, 4'd1, 2'd2, 1'b0}, // R4 alpha limit
    '{14'd1920, 14'd1920, 14'd1920, 2'd2, 1'b0, 1'b0, 1'b0, 4'd4, 4'd4, 4'd1, 4'd1, 2'd1, 1'b0}, // R2 6 bpc
    '{14'd1920, 14'd1920, 14'd1920, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd4, 4'd3, 4'd3, 2'd0, 1'b0}, // R5 ratio
    '{14'd100,  14'd100,  14'd100,  2'd1, 1'b0, 1'b0, 1'b1, 4'd4, 4'd4, 4'd1, 4'd1, 2'd0, 1'b0}, // R7
    '{14'd100,  14'd100,  14'd100,  2'd1, 1'b0, 1'b1, 1'b1, 4'd4, 4'd4, 4'd1, 4'd1, 2'd3, 1'b0}, // R7 420
    '{14'd0,    14'd0,    14'd0,    2'd0, 1'b0, 1'b0, 1'b0, 4'd8, 4'd8, 4'd1, 4'd1, 2'd1, 1'b0}, // R1 zero
    '{14'd64,   14'd1920, 14'd1920, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd4, 4'd1, 4'd1, 2'd2, 1'b0}, // R5 chroma only
    '{14'd3840, 14'd3840, 14'd3840, 2'd3, 1'b0, 1'b0, 1'b0, 4'd3, 4'd3, 4'd3, 4'd3, 2'd0, 1'b0}, // R5 exact edge
    '{14'd3840, 14'd3840, 14'd3840, 2'd3, 1'b0, 1'b0, 1'b0, 4'd4, 4'd4, 4'd3, 4'd3, 2'd0, 1'b1}, // R5 R8 edge+1
    '{14'd1920, 14'd1920, 14'd100,  2'd1, 1'b0, 1'b0, 1'b0, 4'd4, 4'd4, 4'd1, 4'd1, 2'd1, 1'b0}  // R1 out width min
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input vec_t v, input int c, output int py, output int pc);
    int ly, lc, b, my, mc, ma, sy, sc, sa;
    ly = (v.vy < v.ow) ? int'(v.vy) : int'(v.ow);  if (ly == 0) ly = 1;
    lc = (v.vc < v.ow) ? int'(v.vc) : int'(v.ow);  if (lc == 0) lc = 1;
    b  = (v.bc == 0) ? 10 : (v.bc == 1) ? 8 : (v.bc == 2) ? 6 : 12;
    my = (ly * b + 71) / 72;  mc = (lc * b + 71) / 72;  ma = (ly + 5) / 6;
    case (c)
      1: begin sy = 816;  sc = 816;  sa = 984;  end
      2: begin sy = 1088; sc = 1088; sa = 1312; end
      3: begin sy = 3448; sc = 1904; sa = 2752; end
      default: begin sy = 2752; sc = 2752; sa = 2752; end
    endcase
    py = sy / my;  pc = sc / mc;
    if (v.al && sa / ma < py) py = sa / ma;
    if (py > 64) py = 64;
    if (pc > 64) pc = 64;
  endfunction

  task automatic apply(input vec_t v);
    vp_w_y = v.vy; vp_w_c = v.vc; out_w = v.ow; bpc_code = v.bc;
    alpha_en = v.al; is420 = v.f420; use_max = v.um;
    vtaps_y = v.ty; vtaps_c = v.tc; ceil_ry = v.ry; ceil_rc = v.rc;
  endtask

  // start pulse; optional extra start after edge number extra_at; returns edges until valid
  task automatic run(input vec_t v, input int extra_at, output int lat);
    int n = 0;
    @(negedge clk);
    apply(v);
    start = 1'b1;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = (n == extra_at);
      if (n == 1) chk("R9 valid cleared after start", valid, 0);
      if (n > 3000) begin
        chk("watchdog expired", 0, 1);
        break;
      end
    end while (!valid);
    start = 1'b0;
    lat = n;
  endtask

  initial begin
    int lat0, lat1, py, pc;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", valid, 0);
    chk("R9 reset err", err, 0);
    chk("R9 reset cfg", cfg, 0);
    chk("R9 reset parts_y", parts_y, 0);
    chk("R9 reset parts_c", parts_c, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 15; i++) begin
      run(TBL[i], -1, lat0);
      model(TBL[i], TBL[i].ecfg, py, pc);
      chk($sformatf("R6/R7 config vec %0d", i), cfg, TBL[i].ecfg);
      chk($sformatf("R1/R2/R3/R4 luma parts vec %0d", i), parts_y, py);
      chk($sformatf("R1/R2/R3/R4 chroma parts vec %0d", i), parts_c, pc);
      chk($sformatf("R5/R8 error vec %0d", i), err, TBL[i].eerr);
    end

    // R9 hold: results stay for several idle cycles
    run(TBL[5], -1, lat0);
    repeat (6) @(negedge clk);
    chk("R9 valid held", valid, 1);
    chk("R9 cfg held", cfg, 2);

    // R10 mid-search start does not change latency or result
    run(TBL[3], -1, lat0);
    run(TBL[3], 20, lat1);
    chk("R10 latency with mid-search start", lat1, lat0);
    chk("R10 result with mid-search start", cfg, 0);
    chk("R10 err with mid-search start", err, 1);

    // R10 start on the completing edge is dropped
    run(TBL[0], lat0 + 100, lat0);
    run(TBL[0], lat0 - 1, lat1);
    chk("R10 latency with final-cycle start", lat1, lat0);
    repeat (5) @(negedge clk);
    chk("R10 valid after final-cycle start", valid, 1);
    chk("R10 cfg after final-cycle start", cfg, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule